// File: doc/BRIEF.md
# Multi-domain reset and pad controller

This block produces the reset lines for four functional domains of a communications controller: a serial-bus handler, a voice codec, a line transceiver and the core register file. Two sources can put a domain into reset. The first is an active-low asynchronous external reset, which resets everything at once. The second is a small software reset register on a simple single-cycle register bus, which holds one bit per domain. A domain stays in reset while its bit is set.

While a domain is in reset, the block also drives the control that keeps that domain's pads in a safe state. The serial-bus frame-sync pad is forced high and its select pad is forced low. Some pads are released to high impedance. Two pads are floated only during a hardware reset.

A reset-out pin copies the external reset. It asserts at once, but after the external reset is removed it is released only on the next falling edge of the free-running bit clock. The block never gates any clock. Each domain sees only its own reset line.

Top module: `rstpad_ctrl`

## Requirements
- R1: While `rst_ext_n` is low, with no clock edge needed, every `dom_rst_n` bit is 0, `rst_out_n` is 0, all eleven `pad_tri` bits are 1, and `fs_force` and `sel_force` are 1.
- R2: A hardware reset clears the software reset register to 0. A register write issued while `rst_ext_n` is low has no effect.
- R3: The software reset register sits at address `SWRST_ADDR` (default 8'h1A). Bit 0 is the serial-bus domain, bit 1 the codec, bit 2 the transceiver and bit 3 the core. A write with `wr_en` high and a matching `wr_addr` loads `wr_data` on the next clock edge. `rd_data` shows the register when `rd_addr` matches and 0 otherwise. A write to any other address leaves the register unchanged.
- R4: `dom_rst_n[i]` goes low on the second clock edge after the edge that sets bit i. It stays low while the bit is 1, and goes high on the second clock edge after the edge that clears it. Other domains are not affected.
- R5: After `rst_ext_n` rises, every domain reset and the hardware-only pad float are released on the second rising clock edge.
- R6: While the serial-bus domain is in reset, `fs_force` (frame-sync driven high) and `sel_force` (select driven low) are 1. `pad_tri[2:0]` (bit clock, data down, data up) are also 1.
- R7: While the codec domain is in reset, `pad_tri[6:3]` (the four differential outputs) are 1.
- R8: While the transceiver domain is in reset, `pad_tri[8:7]` (the two line pins) are 1.
- R9: `pad_tri[10:9]` (serial data out and interrupt) are 1 only during a hardware reset. No software reset bit sets them.
- R10: `rst_out_n` goes high on the first falling edge of `bclk` after `rst_ext_n` rises, not before. Software reset bits have no effect on it.
- R11: Setting the core bit does not clear or change the software reset register itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; runs during every reset |
| rst_ext_n | input | 1 | External hardware reset, active low, asynchronous |
| bclk | input | 1 | Free-running serial bit clock |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 4 | Register write data, one bit per domain |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 4 | Software reset register when `rd_addr` matches, else 0 |
| dom_rst_n | output | 4 | Per-domain reset, active low (0 serial-bus, 1 codec, 2 transceiver, 3 core) |
| rst_out_n | output | 1 | Reset-out pin copy of the hardware reset |
| pad_tri | output | 11 | High-impedance request per pad (1 = float) |
| fs_force | output | 1 | 1 = drive frame-sync pad high |
| sel_force | output | 1 | 1 = drive select pad low |

## Verification
Each domain's reset pipeline holds its state in a short shift register. A wrong stage count or a wrong reset value moves the release or assertion of `dom_rst_n` and its pad group by one or more clock cycles. That shift shows at the ports within three cycles of the register write.

A corrupted software reset register shows on `rd_data` on the cycle after the write. It also reaches `dom_rst_n` two cycles later.

A reset-out stage clocked on the wrong bit-clock edge releases `rst_out_n` half a bit period early, before the falling edge. A stage that ignored the bit clock releases it at once.

A pad mapped to the wrong domain leaves that pad floating, or driving, against the pattern of the reset that is active.

// File: rtl/rstpad_pkg.sv
`timescale 1ns/1ps
package rstpad_pkg;
  // domain indices: bit order of the software reset register
  localparam int DOM_N     = 4;
  localparam int DOM_SBUS  = 0;
  localparam int DOM_CODEC = 1;
  localparam int DOM_LINE  = 2;
  localparam int DOM_CORE  = 3;

  // pad control vector
  localparam int PAD_N     = 11;
  localparam int HW_PAD_LO = 9;
  localparam int OWNER_HW  = DOM_N;

  // which reset source owns each pad position
  function automatic int pad_owner(input int p);
    if (p < 3)              return DOM_SBUS;
    else if (p < 7)         return DOM_CODEC;
    else if (p < HW_PAD_LO) return DOM_LINE;
    else                    return OWNER_HW;
  endfunction
endpackage

// File: rtl/rstpad_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module rstpad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rstpad_swreg.sv
`timescale 1ns/1ps
// Software reset register: one level-held bit per domain.
module rstpad_swreg #(
  parameter int                ADDR_W   = 8,
  parameter int                DOM_N    = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DOM_N-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DOM_N-1:0]  sw_q,
  output logic [DOM_N-1:0]  rd_data
);
  logic             wr_hit;
  logic [DOM_N-1:0] sw_d;

  always_comb begin
    wr_hit = wr_en && (wr_addr == REG_ADDR);
    sw_d   = wr_hit ? wr_data : sw_q;
  end

  // only the hardware reset clears this register
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     sw_q <= '0;
    else if (wr_hit) sw_q <= sw_d;
  end

  always_comb begin
    rd_data = (rd_addr == REG_ADDR) ? sw_q : '0;
  end
endmodule

// File: rtl/rstpad_outrel.sv
`timescale 1ns/1ps
// Reset-out stage: cleared at once, set on a falling bit-clock edge.
module rstpad_outrel (
  input  logic bclk,
  input  logic arst_n,
  output logic rel_n
);
  logic rel_d;

  always_comb begin
    rel_d = 1'b1;
  end

  always_ff @(negedge bclk or negedge arst_n) begin
    if (!arst_n) rel_n <= 1'b0;
    else         rel_n <= rel_d;
  end
endmodule

// File: rtl/rstpad_padmap.sv
`timescale 1ns/1ps
// Maps the domain resets onto pad float and force controls.
module rstpad_padmap
  import rstpad_pkg::*;
(
  input  logic [DOM_LINE:0] pad_dom_rst_n,
  input  logic              hw_rst_n,
  output logic [PAD_N-1:0]  pad_tri,
  output logic              fs_force,
  output logic              sel_force
);
  for (genvar p = 0; p < PAD_N; p++) begin : g_pad
    if (pad_owner(p) == OWNER_HW) begin : g_hw
      assign pad_tri[p] = ~hw_rst_n;
    end else begin : g_dom
      assign pad_tri[p] = ~pad_dom_rst_n[pad_owner(p)];
    end
  end

  assign fs_force  = ~pad_dom_rst_n[DOM_SBUS];
  assign sel_force = ~pad_dom_rst_n[DOM_SBUS];
endmodule

// File: rtl/rstpad_ctrl.sv
`timescale 1ns/1ps
module rstpad_ctrl
  import rstpad_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] SWRST_ADDR  = 8'h1A,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_ext_n,
  input  logic              bclk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DOM_N-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DOM_N-1:0]  rd_data,
  output logic [DOM_N-1:0]  dom_rst_n,
  output logic              rst_out_n,
  output logic [PAD_N-1:0]  pad_tri,
  output logic              fs_force,
  output logic              sel_force
);
  logic [DOM_N-1:0] sw_q;
  logic             hw_rst_n;

  rstpad_swreg #(
    .ADDR_W(ADDR_W), .DOM_N(DOM_N), .REG_ADDR(SWRST_ADDR)
  ) u_swreg (
    .clk(clk), .arst_n(rst_ext_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .sw_q(sw_q), .rd_data(rd_data)
  );

  // per-domain reset = hardware reset OR software bit
  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    rstpad_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .arst_n(rst_ext_n), .d(~sw_q[d]), .q(dom_rst_n[d])
    );
  end

  rstpad_sync #(.STAGES(SYNC_STAGES)) u_hwsync (
    .clk(clk), .arst_n(rst_ext_n), .d(1'b1), .q(hw_rst_n)
  );

  rstpad_outrel u_outrel (
    .bclk(bclk), .arst_n(rst_ext_n), .rel_n(rst_out_n)
  );

  rstpad_padmap u_padmap (
    .pad_dom_rst_n(dom_rst_n[DOM_LINE:0]), .hw_rst_n(hw_rst_n),
    .pad_tri(pad_tri), .fs_force(fs_force), .sel_force(sel_force)
  );
endmodule

// File: rtl/rstpad_ctrl_chk.sv
`timescale 1ns/1ps
module rstpad_ctrl_chk
  import rstpad_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] SWRST_ADDR = '0
) (
  input logic              clk,
  input logic              rst_ext_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DOM_N-1:0]  sw_q,
  input logic [DOM_N-1:0]  dom_rst_n,
  input logic [PAD_N-1:0]  pad_tri
);
  for (genvar i = 0; i < DOM_N; i++) begin : g_chk
    AST_SW_BIT_HOLDS_DOMAIN: assert property (@(posedge clk) disable iff (!rst_ext_n)
      (sw_q[i] && $past(sw_q[i]) && $past(sw_q[i], 2)) |-> !dom_rst_n[i]); // R4
    AST_CLEAR_BIT_FREES_DOMAIN: assert property (@(posedge clk) disable iff (!rst_ext_n)
      (!sw_q[i] && !$past(sw_q[i]) && !$past(sw_q[i], 2)
       && $past(rst_ext_n) && $past(rst_ext_n, 2)) |-> dom_rst_n[i]); // R4
  end

  AST_HW_PADS_ONLY_HW: assert property (@(posedge clk) disable iff (!rst_ext_n)
    ($past(rst_ext_n) && $past(rst_ext_n, 2)) |-> (pad_tri[HW_PAD_LO +: 2] == 2'b00)); // R9
  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_ext_n)
    (wr_en && wr_addr != SWRST_ADDR) |=> $stable(sw_q)); // R3
  AST_REG_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_ext_n)
    !(wr_en && wr_addr == SWRST_ADDR) |=> $stable(sw_q)); // R11
endmodule

bind rstpad_ctrl rstpad_ctrl_chk #(
  .ADDR_W(ADDR_W), .SWRST_ADDR(SWRST_ADDR)
) u_chk (
  .clk(clk), .rst_ext_n(rst_ext_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .sw_q(sw_q), .dom_rst_n(dom_rst_n), .pad_tri(pad_tri)
);

// File: tb/sim_rstpad_ctrl.sv
`timescale 1ns/1ps
module sim_rstpad_ctrl;
  localparam logic [7:0] REG_A = 8'h1A;
  localparam logic [21:0] ALL = '1;

  logic       clk = 1'b0;
  logic       bclk = 1'b0;
  logic       rst_ext_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [7:0] rd_addr = REG_A;
  logic [3:0] rd_data, dom_rst_n;
  logic       rst_out_n, fs_force, sel_force;
  logic [10:0] pad_tri;

  rstpad_ctrl u0 (
    .clk(clk), .rst_ext_n(rst_ext_n), .bclk(bclk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dom_rst_n(dom_rst_n), .rst_out_n(rst_out_n), .pad_tri(pad_tri),
    .fs_force(fs_force), .sel_force(sel_force)
  );

  always #5 clk = ~clk;                       // 100 MHz
  initial begin #23; forever #40 bclk = ~bclk; end  // edges never on a clk edge

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    string       req;
    logic [21:0] exp;
    logic [21:0] mask;
  } item_t;
  item_t sb[$];
  item_t it;
  int n_chk = 0, n_fail = 0;

  wire [21:0] obs = {rd_data, sel_force, fs_force, pad_tri, rst_out_n, dom_rst_n};

  // expected port image: dom = domains in reset, hwp = hardware pad float
  function automatic logic [21:0] model(logic [3:0] dom, logic hwp, logic ro, logic [3:0] rd);
    logic [10:0] p;
    p = {{2{hwp}}, {2{dom[2]}}, {4{dom[1]}}, {3{dom[0]}}};
    return {rd, dom[0], dom[0], p, ro, ~dom};
  endfunction

  task automatic expect_at(int due, string req, logic [21:0] e);
    item_t x;
    x.due = due; x.req = req; x.exp = e; x.mask = ALL;
    sb.push_back(x);
  endtask

  // monitor: pops due items and compares away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      n_chk++;
      if (((obs ^ it.exp) & it.mask) != '0) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h (cycle %0d)", it.req, obs, it.exp, cyc);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic hw_release();
    int c;
    @(posedge bclk); @(posedge clk); #2;
    rst_ext_n = 1'b1; c = cyc;
    expect_at(c,   "R5 still held at release",        model(4'hF, 1'b1, 1'b0, 4'h0));
    expect_at(c+1, "R5 held one edge after release",  model(4'hF, 1'b1, 1'b0, 4'h0));
    expect_at(c+2, "R5 released on second edge",      model(4'h0, 1'b0, 1'b0, 4'h0));
    expect_at(c+3, "R10 waits for bit-clock fall",    model(4'h0, 1'b0, 1'b0, 4'h0));
    expect_at(c+4, "R10 released after bit-clock fall", model(4'h0, 1'b0, 1'b1, 4'h0));
    tick(6);
  endtask

  bit done = 1'b0;
  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c;
    tick(2);
    expect_at(cyc, "R1 all held in reset", model(4'hF, 1'b1, 1'b0, 4'h0));
    c = cyc; wr(REG_A, 4'hF);
    expect_at(c+1, "R2 write during reset ignored", model(4'hF, 1'b1, 1'b0, 4'h0));
    tick(2);
    hw_release();

    c = cyc; wr(REG_A, 4'b0001);
    expect_at(c+1, "R3 readback", model(4'h0, 1'b0, 1'b1, 4'h1));
    expect_at(c+2, "R4 two-edge latency", model(4'h0, 1'b0, 1'b1, 4'h1));
    expect_at(c+3, "R6 serial-bus pads", model(4'h1, 1'b0, 1'b1, 4'h1));
    tick(4);

    c = cyc; wr(REG_A, 4'b0110);
    expect_at(c+1, "R3 readback", model(4'h1, 1'b0, 1'b1, 4'h6));
    expect_at(c+2, "R4 old domains kept", model(4'h1, 1'b0, 1'b1, 4'h6));
    expect_at(c+3, "R7 codec pads", model(4'h6, 1'b0, 1'b1, 4'h6));
    expect_at(c+3, "R8 line pads", model(4'h6, 1'b0, 1'b1, 4'h6));
    tick(4);

    c = cyc; wr(8'h1B, 4'h0);
    expect_at(c+1, "R3 foreign address write", model(4'h6, 1'b0, 1'b1, 4'h6));
    expect_at(c+3, "R3 foreign address write", model(4'h6, 1'b0, 1'b1, 4'h6));
    tick(4);
    rd_addr = 8'h05;
    expect_at(cyc, "R3 read of other address", model(4'h6, 1'b0, 1'b1, 4'h0));
    tick(1);
    rd_addr = REG_A;
    tick(2);

    c = cyc; wr(REG_A, 4'b1000);
    expect_at(c+2, "R4 core not yet", model(4'h6, 1'b0, 1'b1, 4'h8));
    expect_at(c+3, "R4 core domain", model(4'h8, 1'b0, 1'b1, 4'h8));
    tick(8);
    expect_at(cyc, "R11 core reset keeps register", model(4'h8, 1'b0, 1'b1, 4'h8));
    tick(1);

    c = cyc; wr(REG_A, 4'hF);
    expect_at(c+3, "R9 hw pads not floated by software", model(4'hF, 1'b0, 1'b1, 4'hF));
    expect_at(c+4, "R10 reset out unaffected by software", model(4'hF, 1'b0, 1'b1, 4'hF));
    tick(5);

    c = cyc; wr(REG_A, 4'h0);
    expect_at(c+2, "R4 held until second edge", model(4'hF, 1'b0, 1'b1, 4'h0));
    expect_at(c+3, "R4 released", model(4'h0, 1'b0, 1'b1, 4'h0));
    tick(4);

    wr(REG_A, 4'h5);
    tick(4);
    #1; rst_ext_n = 1'b0;
    expect_at(cyc, "R1 asynchronous assertion", model(4'hF, 1'b1, 1'b0, 4'h0));
    tick(3);
    hw_release();
    expect_at(cyc, "R2 register cleared by hardware reset", model(4'h0, 1'b0, 1'b1, 4'h0));
    tick(2);

    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule